// File: doc/BRIEF.md
# Inverted Page Table Hash Walker

This block resolves a translation against a single system-wide inverted page table, where slot *n* of the table describes physical frame *n*. A request carries an address space identifier and a virtual page number. The block folds both into a bucket index and reads that bucket's anchor word from an external anchor table. The anchor word is the index of the first table slot in the bucket's collision chain. The block then reads slots one after another through an external slot read port. It checks the stored identifier and page number of each slot against the request, until it finds a match, reaches the end of the chain, or reaches a configured probe budget.

Only one search runs at a time. The requester sees a ready signal that drops for the length of the search. Results come back on a one-cycle response strobe. The response holds a hit flag, the frame number (the index of the matching slot), how many slots were examined, and a flag that shows whether the probe budget stopped the search. The tables are written by other logic and hold whatever that logic left there. Each external read returns its word one cycle after the read is issued.

Top module: `ipt_hash_lookup`

## Requirements
- R1: After reset, req_ready is 1 and rsp_valid, bkt_rd_en and ent_rd_en are all 0 while req_valid is 0.
- R2: When a request is accepted (req_valid and req_ready both 1), bkt_rd_en is 1 in that same cycle. Bit i of bkt_rd_addr is then the XOR of every req_asid bit j and every req_vpn bit j for which j mod BKT_W equals i.
- R3: An anchor word of all ones marks an empty bucket. The search then ends as a miss with rsp_probes 0 and rsp_limit 0, and no slot is read.
- R4: A slot word is {valid[MSB], asid, vpn, next[FRAME_W-1:0]}. A hit needs the valid bit set and both the stored asid and the stored vpn equal to the request. rsp_frame is then the slot index. On a miss rsp_frame is 0.
- R5: Slots are visited in chain order: first the anchor index, then each slot's next field. rsp_probes counts every slot read, including the slot that hit.
- R6: A slot with its valid bit clear never hits, even when its fields match. Its next field is still followed.
- R7: A next field of all ones ends the chain. A search that reaches this without a hit is a miss with rsp_limit 0.
- R8: If MAX_CHAIN slots have been examined without a hit and the chain still continues, the search ends as a miss with rsp_limit 1 and rsp_probes equal to MAX_CHAIN. A hit or a chain end at the MAX_CHAIN-th slot reports rsp_limit 0.
- R9: From acceptance until the response, req_ready is 0. Requests raised in that window are neither accepted nor answered, and they do not read the anchor table.
- R10: rsp_valid is high for exactly one cycle. It rises at the (rsp_probes+1)-th rising edge after the accepting edge.
- R11: Slot reads never address the all-ones index. Read data is expected one cycle after the read is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Walker idle; request accepted this cycle if valid |
| req_asid | input | ASID_W | Address space identifier of the request |
| req_vpn | input | VPN_W | Virtual page number of the request |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_hit | output | 1 | Translation found |
| rsp_frame | output | FRAME_W | Frame number on a hit, 0 on a miss |
| rsp_probes | output | CNT_W | Slots examined |
| rsp_limit | output | 1 | Search stopped by the probe budget |
| bkt_rd_en | output | 1 | Anchor table read strobe |
| bkt_rd_addr | output | BKT_W | Anchor table index (hash) |
| bkt_rd_data | input | FRAME_W | Anchor word, one cycle after the strobe |
| ent_rd_en | output | 1 | Slot read strobe |
| ent_rd_addr | output | FRAME_W | Slot index |
| ent_rd_data | input | 1+ASID_W+VPN_W+FRAME_W | Slot word, one cycle after the strobe |

## Verification
The bench builds the walker with ASID_W=4, VPN_W=8, BKT_W=3, FRAME_W=4 and MAX_CHAIN=4. This gives a 16-slot table and 8 buckets. With those sizes the bench can hold empty buckets, a five-slot chain that crosses the budget, and a two-slot loop that only the budget can end. Identifier and page bits above the bucket width take part in the hash, so the folding is visible on the anchor address. A hit that lands exactly on the fourth probe shows where the budget boundary sits.

// File: rtl/ipt_pkg.sv
package ipt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_HEAD  = 2'd1,
    ST_PROBE = 2'd2,
    ST_DONE  = 2'd3
  } walk_st_e;

endpackage

// File: rtl/ipt_hash_fold.sv
module ipt_hash_fold #(
  parameter int ASID_W = 12,
  parameter int VPN_W  = 36,
  parameter int BKT_W  = 12
) (
  input  logic [ASID_W-1:0] key_asid,
  input  logic [VPN_W-1:0]  key_vpn,
  output logic [BKT_W-1:0]  bucket
);

  // every source bit lands on position (bit index mod BKT_W)
  function automatic logic [BKT_W-1:0] fold_asid(input logic [ASID_W-1:0] x);
    logic [BKT_W-1:0] r;
    r = '0;
    for (int j = 0; j < ASID_W; j++) r[j % BKT_W] = r[j % BKT_W] ^ x[j];
    return r;
  endfunction

  function automatic logic [BKT_W-1:0] fold_vpn(input logic [VPN_W-1:0] x);
    logic [BKT_W-1:0] r;
    r = '0;
    for (int j = 0; j < VPN_W; j++) r[j % BKT_W] = r[j % BKT_W] ^ x[j];
    return r;
  endfunction

  assign bucket = fold_asid(key_asid) ^ fold_vpn(key_vpn);

endmodule

// File: rtl/ipt_entry_cmp.sv
module ipt_entry_cmp #(
  parameter int ASID_W  = 12,
  parameter int VPN_W   = 36,
  parameter int FRAME_W = 16,
  localparam int ENT_W  = 1 + ASID_W + VPN_W + FRAME_W
) (
  input  logic [ENT_W-1:0]   ent_word,
  input  logic [ASID_W-1:0]  key_asid,
  input  logic [VPN_W-1:0]   key_vpn,
  output logic               ent_valid,
  output logic               ent_match,
  output logic [FRAME_W-1:0] ent_next,
  output logic               ent_last
);

  logic [ASID_W-1:0] st_asid;
  logic [VPN_W-1:0]  st_vpn;

  assign ent_valid = ent_word[ENT_W-1];
  assign st_asid   = ent_word[ENT_W-2 -: ASID_W];
  assign st_vpn    = ent_word[FRAME_W +: VPN_W];
  assign ent_next  = ent_word[FRAME_W-1:0];

  assign ent_match = ent_valid && (st_asid == key_asid) && (st_vpn == key_vpn);
  assign ent_last  = &ent_next;

endmodule

// File: rtl/ipt_walk_ctrl.sv
module ipt_walk_ctrl
  import ipt_pkg::*;
#(
  parameter int ASID_W    = 12,
  parameter int VPN_W     = 36,
  parameter int FRAME_W   = 16,
  parameter int MAX_CHAIN = 32,
  localparam int CNT_W    = $clog2(MAX_CHAIN + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [ASID_W-1:0]  req_asid,
  input  logic [VPN_W-1:0]   req_vpn,
  output logic [ASID_W-1:0]  key_asid,
  output logic [VPN_W-1:0]   key_vpn,
  input  logic [FRAME_W-1:0] bkt_head,
  input  logic               ent_valid,
  input  logic               ent_match,
  input  logic [FRAME_W-1:0] ent_next,
  input  logic               ent_last,
  output logic               ent_rd_en,
  output logic [FRAME_W-1:0] ent_rd_addr,
  output logic               rsp_valid,
  output logic               rsp_hit,
  output logic [FRAME_W-1:0] rsp_frame,
  output logic [CNT_W-1:0]   rsp_probes,
  output logic               rsp_limit
);

  walk_st_e           state_q;
  logic [FRAME_W-1:0] cur_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [CNT_W-1:0]   cnt_inc;

  // named events of the walk, used by the logic and by the checks
  logic accept_evt, empty_evt, probe_evt, hit_evt, end_evt, limit_evt, step_evt, skip_evt;
  logic at_budget;

  assign req_ready  = (state_q == ST_IDLE);
  assign accept_evt = req_valid && req_ready;
  assign empty_evt  = (state_q == ST_HEAD) && (&bkt_head);
  assign probe_evt  = (state_q == ST_PROBE);
  assign cnt_inc    = cnt_q + CNT_W'(1);
  assign at_budget  = (cnt_inc == CNT_W'(MAX_CHAIN));
  assign hit_evt    = probe_evt && ent_match;
  assign skip_evt   = probe_evt && !ent_valid;
  assign end_evt    = probe_evt && !ent_match && ent_last;
  assign limit_evt  = probe_evt && !ent_match && !ent_last && at_budget;
  assign step_evt   = probe_evt && !ent_match && !ent_last && !at_budget;

  assign ent_rd_en   = ((state_q == ST_HEAD) && !empty_evt) || step_evt;
  assign ent_rd_addr = (state_q == ST_HEAD) ? bkt_head : ent_next;
  assign rsp_valid   = (state_q == ST_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      cur_q      <= '0;
      cnt_q      <= '0;
      key_asid   <= '0;
      key_vpn    <= '0;
      rsp_hit    <= 1'b0;
      rsp_frame  <= '0;
      rsp_probes <= '0;
      rsp_limit  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (accept_evt) begin
            key_asid <= req_asid;
            key_vpn  <= req_vpn;
            cnt_q    <= '0;
            state_q  <= ST_HEAD;
          end
        end
        ST_HEAD: begin
          if (empty_evt) begin
            rsp_hit    <= 1'b0;
            rsp_frame  <= '0;
            rsp_probes <= '0;
            rsp_limit  <= 1'b0;
            state_q    <= ST_DONE;
          end else begin
            cur_q   <= bkt_head;
            state_q <= ST_PROBE;
          end
        end
        ST_PROBE: begin
          cnt_q <= cnt_inc;
          if (hit_evt) begin
            rsp_hit    <= 1'b1;
            rsp_frame  <= cur_q;
            rsp_probes <= cnt_inc;
            rsp_limit  <= 1'b0;
            state_q    <= ST_DONE;
          end else if (end_evt || limit_evt) begin
            rsp_hit    <= 1'b0;
            rsp_frame  <= '0;
            rsp_probes <= cnt_inc;
            rsp_limit  <= limit_evt;
            state_q    <= ST_DONE;
          end else begin
            cur_q <= ent_next;
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R10
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R9
  idle_after_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> req_ready);

  // R9
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> !req_ready && !rsp_valid);

  // R8
  budget_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_limit |-> !rsp_hit && (rsp_probes == CNT_W'(MAX_CHAIN)));

  // R5
  probe_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_probes <= CNT_W'(MAX_CHAIN));

  // R4
  hit_probed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_hit |-> rsp_probes != '0);

  // R6
  skip_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    skip_evt |=> !(rsp_valid && rsp_hit));

  // R11
  no_null_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ent_rd_en |-> !(&ent_rd_addr));

  // R11
  read_then_probe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ent_rd_en |=> !req_ready && !rsp_valid);

endmodule

// File: rtl/ipt_hash_lookup.sv
module ipt_hash_lookup #(
  parameter int ASID_W    = 12,
  parameter int VPN_W     = 36,
  parameter int FRAME_W   = 16,
  parameter int BKT_W     = 12,
  parameter int MAX_CHAIN = 32,
  localparam int CNT_W    = $clog2(MAX_CHAIN + 1),
  localparam int ENT_W    = 1 + ASID_W + VPN_W + FRAME_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [ASID_W-1:0]  req_asid,
  input  logic [VPN_W-1:0]   req_vpn,
  output logic               rsp_valid,
  output logic               rsp_hit,
  output logic [FRAME_W-1:0] rsp_frame,
  output logic [CNT_W-1:0]   rsp_probes,
  output logic               rsp_limit,
  output logic               bkt_rd_en,
  output logic [BKT_W-1:0]   bkt_rd_addr,
  input  logic [FRAME_W-1:0] bkt_rd_data,
  output logic               ent_rd_en,
  output logic [FRAME_W-1:0] ent_rd_addr,
  input  logic [ENT_W-1:0]   ent_rd_data
);

  logic [ASID_W-1:0]  key_asid;
  logic [VPN_W-1:0]   key_vpn;
  logic               ent_valid, ent_match, ent_last;
  logic [FRAME_W-1:0] ent_next;

  ipt_hash_fold #(
    .ASID_W(ASID_W), .VPN_W(VPN_W), .BKT_W(BKT_W)
  ) u_hash (
    .key_asid(req_asid),
    .key_vpn (req_vpn),
    .bucket  (bkt_rd_addr)
  );

  assign bkt_rd_en = req_valid && req_ready;

  ipt_entry_cmp #(
    .ASID_W(ASID_W), .VPN_W(VPN_W), .FRAME_W(FRAME_W)
  ) u_cmp (
    .ent_word (ent_rd_data),
    .key_asid (key_asid),
    .key_vpn  (key_vpn),
    .ent_valid(ent_valid),
    .ent_match(ent_match),
    .ent_next (ent_next),
    .ent_last (ent_last)
  );

  ipt_walk_ctrl #(
    .ASID_W(ASID_W), .VPN_W(VPN_W), .FRAME_W(FRAME_W), .MAX_CHAIN(MAX_CHAIN)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_asid   (req_asid),
    .req_vpn    (req_vpn),
    .key_asid   (key_asid),
    .key_vpn    (key_vpn),
    .bkt_head   (bkt_rd_data),
    .ent_valid  (ent_valid),
    .ent_match  (ent_match),
    .ent_next   (ent_next),
    .ent_last   (ent_last),
    .ent_rd_en  (ent_rd_en),
    .ent_rd_addr(ent_rd_addr),
    .rsp_valid  (rsp_valid),
    .rsp_hit    (rsp_hit),
    .rsp_frame  (rsp_frame),
    .rsp_probes (rsp_probes),
    .rsp_limit  (rsp_limit)
  );

  // R2
  anchor_on_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bkt_rd_en |=> !req_ready);

  // R3
  empty_bucket_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_probes == '0 |-> !rsp_hit && !rsp_limit);

  // R4
  miss_frame_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_hit |-> rsp_frame == '0);

endmodule

// File: tb/tb_ipt_hash_lookup.sv
module tb_ipt_hash_lookup;

  localparam int AW = 4, VW = 8, FW = 4, BW = 3, MC = 4;
  localparam int CW = $clog2(MC + 1);
  localparam int EW = 1 + AW + VW + FW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_asid = '0;
  logic [VW-1:0] req_vpn = '0;
  logic          rsp_valid, rsp_hit, rsp_limit;
  logic [FW-1:0] rsp_frame;
  logic [CW-1:0] rsp_probes;
  logic          bkt_rd_en, ent_rd_en;
  logic [BW-1:0] bkt_rd_addr;
  logic [FW-1:0] bkt_rd_data, ent_rd_addr;
  logic [EW-1:0] ent_rd_data;

  logic [FW-1:0] bkt_mem [1<<BW];
  logic [EW-1:0] ent_mem [1<<FW];

  always @(posedge clk) begin
    if (bkt_rd_en) bkt_rd_data <= bkt_mem[bkt_rd_addr];
    if (ent_rd_en) ent_rd_data <= ent_mem[ent_rd_addr];
  end

  ipt_hash_lookup #(
    .ASID_W(AW), .VPN_W(VW), .FRAME_W(FW), .BKT_W(BW), .MAX_CHAIN(MC)
  ) dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_asid(req_asid), .req_vpn(req_vpn),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_frame(rsp_frame),
    .rsp_probes(rsp_probes), .rsp_limit(rsp_limit),
    .bkt_rd_en(bkt_rd_en), .bkt_rd_addr(bkt_rd_addr), .bkt_rd_data(bkt_rd_data),
    .ent_rd_en(ent_rd_en), .ent_rd_addr(ent_rd_addr), .ent_rd_data(ent_rd_data)
  );

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // hash restated as chunk-wise XOR of BW-bit slices
  function automatic logic [BW-1:0] ref_bucket(input logic [AW-1:0] a, input logic [VW-1:0] v);
    logic [BW-1:0] h;
    logic [VW-1:0] t;
    logic [AW-1:0] s;
    h = '0; t = v; s = a;
    while (t != '0) begin h = h ^ t[BW-1:0]; t = t >> BW; end
    while (s != '0) begin h = h ^ s[BW-1:0]; s = s >> BW; end
    return h;
  endfunction

  function automatic logic [EW-1:0] slot(input bit vld, input logic [AW-1:0] a,
                                         input logic [VW-1:0] v, input logic [FW-1:0] nx);
    return {vld, a, v, nx};
  endfunction

  typedef struct packed {
    logic [AW-1:0] asid;
    logic [VW-1:0] vpn;
    logic          hit;
    logic [FW-1:0] frame;
    logic [CW-1:0] probes;
    logic          lim;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{4'h0, 8'h00, 1'b0, 4'd0,  3'd0, 1'b0},  // R3 empty bucket 0
    '{4'h1, 8'h00, 1'b1, 4'd3,  3'd1, 1'b0},  // R4 head hit
    '{4'h0, 8'h01, 1'b1, 4'd9,  3'd3, 1'b0},  // R6 passes invalid slot 5
    '{4'h2, 8'h03, 1'b0, 4'd0,  3'd3, 1'b0},  // R6 invalid slot matches fields, R7 end
    '{4'h2, 8'h00, 1'b1, 4'd4,  3'd1, 1'b0},  // R5
    '{4'h3, 8'h01, 1'b1, 4'd6,  3'd2, 1'b0},  // R5
    '{4'h1, 8'h03, 1'b1, 4'd8,  3'd4, 1'b0},  // R8 hit on last allowed probe
    '{4'h4, 8'h06, 1'b0, 4'd0,  3'd4, 1'b1},  // R8 budget reached
    '{4'h3, 8'h00, 1'b1, 4'd11, 3'd1, 1'b0},  // R4
    '{4'h1, 8'h02, 1'b1, 4'd12, 3'd2, 1'b0},  // R5
    '{4'h2, 8'h01, 1'b0, 4'd0,  3'd4, 1'b1},  // R8 looping chain
    '{4'h4, 8'h00, 1'b1, 4'd2,  3'd1, 1'b0},  // R4
    '{4'h5, 8'h01, 1'b1, 4'd13, 3'd2, 1'b0},  // R5
    '{4'h5, 8'h08, 1'b0, 4'd0,  3'd2, 1'b0},  // R4 asid equal, vpn differs
    '{4'hC, 8'h40, 1'b0, 4'd0,  3'd2, 1'b0},  // R2 upper bits folded
    '{4'h6, 8'h00, 1'b1, 4'd14, 3'd1, 1'b0},  // R4
    '{4'h0, 8'h06, 1'b0, 4'd0,  3'd2, 1'b0},  // R4 vpn equal, asid differs
    '{4'h7, 8'h00, 1'b0, 4'd0,  3'd1, 1'b0},  // R6 lone invalid slot
    '{4'hA, 8'h06, 1'b0, 4'd0,  3'd0, 1'b0}   // R3 empty bucket 5
  };

  task automatic lookup(input logic [AW-1:0] a, input logic [VW-1:0] v,
                        output logic [BW-1:0] haddr, output bit hen, output int lat);
    @(negedge clk);
    req_valid = 1'b1; req_asid = a; req_vpn = v;
    #1;
    haddr = bkt_rd_addr;
    hen   = bkt_rd_en;
    @(posedge clk);
    lat = 0;
    while (lat < 60) begin
      @(negedge clk);
      req_valid = 1'b0;
      lat++;
      if (rsp_valid) break;
    end
  endtask

  initial begin
    logic [BW-1:0] ha;
    bit he;
    int lat;
    int extra;

    for (int b = 0; b < (1 << BW); b++) bkt_mem[b] = '1;
    for (int e = 0; e < (1 << FW); e++) ent_mem[e] = '0;
    bkt_mem[1] = 4'd3;  bkt_mem[2] = 4'd4;  bkt_mem[3] = 4'd11;
    bkt_mem[4] = 4'd2;  bkt_mem[6] = 4'd14; bkt_mem[7] = 4'd1;
    ent_mem[0]  = slot(1, 4'hA, 8'h06, 4'hF);
    ent_mem[1]  = slot(0, 4'h7, 8'h00, 4'hF);
    ent_mem[2]  = slot(1, 4'h4, 8'h00, 4'd13);
    ent_mem[3]  = slot(1, 4'h1, 8'h00, 4'd5);
    ent_mem[4]  = slot(1, 4'h2, 8'h00, 4'd6);
    ent_mem[5]  = slot(0, 4'h2, 8'h03, 4'd9);
    ent_mem[6]  = slot(1, 4'h3, 8'h01, 4'd7);
    ent_mem[7]  = slot(1, 4'h0, 8'h02, 4'd8);
    ent_mem[8]  = slot(1, 4'h1, 8'h03, 4'd10);
    ent_mem[9]  = slot(1, 4'h0, 8'h01, 4'hF);
    ent_mem[10] = slot(1, 4'h4, 8'h06, 4'hF);
    ent_mem[11] = slot(1, 4'h3, 8'h00, 4'd12);
    ent_mem[12] = slot(1, 4'h1, 8'h02, 4'd11);
    ent_mem[13] = slot(1, 4'h5, 8'h01, 4'hF);
    ent_mem[14] = slot(1, 4'h6, 8'h00, 4'd0);

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(req_ready == 1'b1, "R1 req_ready", req_ready, 1);
    chk(rsp_valid == 1'b0, "R1 rsp_valid", rsp_valid, 0);
    chk(bkt_rd_en == 1'b0 && ent_rd_en == 1'b0, "R1 reads idle", bkt_rd_en + ent_rd_en, 0);

    for (int i = 0; i < NV; i++) begin
      lookup(VECS[i].asid, VECS[i].vpn, ha, he, lat);
      chk(he == 1'b1, "R2 anchor strobe", he, 1);
      chk(ha == ref_bucket(VECS[i].asid, VECS[i].vpn), "R2 hash", ha,
          ref_bucket(VECS[i].asid, VECS[i].vpn));
      chk(rsp_valid == 1'b1, "R10 response seen", rsp_valid, 1);
      chk(rsp_hit == VECS[i].hit, "R4 hit", rsp_hit, VECS[i].hit);
      chk(rsp_frame == VECS[i].frame, "R4 frame", rsp_frame, VECS[i].frame);
      chk(rsp_probes == VECS[i].probes, "R5 probes", rsp_probes, VECS[i].probes);
      chk(rsp_limit == VECS[i].lim, "R8 limit", rsp_limit, VECS[i].lim);
      chk(lat == int'(VECS[i].probes) + 2, "R10 latency", lat, int'(VECS[i].probes) + 2);
      @(negedge clk);
      chk(rsp_valid == 1'b0, "R10 single pulse", rsp_valid, 0);
      chk(req_ready == 1'b1, "R9 ready again", req_ready, 1);
    end

    // R9: requests during a busy walk are dropped
    @(negedge clk);
    req_valid = 1'b1; req_asid = 4'h2; req_vpn = 8'h01;
    @(posedge clk);
    @(negedge clk);
    req_asid = 4'h1; req_vpn = 8'h00;
    for (int k = 0; k < 3; k++) begin
      #1;
      chk(req_ready == 1'b0, "R9 busy ready low", req_ready, 0);
      chk(bkt_rd_en == 1'b0, "R9 busy no anchor read", bkt_rd_en, 0);
      @(negedge clk);
    end
    req_valid = 1'b0;
    lat = 0;
    while (!rsp_valid && lat < 60) begin @(negedge clk); lat++; end
    chk(rsp_valid && !rsp_hit && rsp_limit, "R9 first request answered", rsp_hit, 0);
    extra = 0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (rsp_valid) extra++;
    end
    chk(extra == 0, "R9 dropped request unanswered", extra, 0);

    // R11: slot reads into a bucket pointing at slot 15 would be illegal; empty bucket reads none
    @(negedge clk);
    req_valid = 1'b1; req_asid = 4'h0; req_vpn = 8'h00;
    @(posedge clk);
    extra = 0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      req_valid = 1'b0;
      if (ent_rd_en) extra++;
    end
    chk(extra == 0, "R11 no slot read on empty bucket", extra, 0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog R10 actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule